// File: doc/BRIEF.md
# DMA Transaction Handler for a Coherence Directory

This block sits on the DMA side of a cache-coherence directory and serves several DMA engines at the same time. Each read or write request arrives with the ID of the engine that sent it. The block opens a transaction slot for the line and stores that ID in it. It then starts the memory traffic the line needs. A read of a clean line fetches the block from memory. A write to a clean line becomes a partial memory write. A read of a line that a cache holds modified first recalls the line from that cache with an invalidate.

When memory or the owning cache answers, the block forms a response and sends it to the engine stored in the slot. A read gets the whole block; the engine picks out its own bytes. A write gets an acknowledgement. The slot is then released, and the line address is announced on a wake output so that stalled requests can retry. Because each response is steered by the stored ID, any number of engines up to the slot count can have work outstanding at once. Responses may also complete in any order.

A request is held at its input while it cannot be taken. This happens when its line already has an open slot, when no slot is free, or when the queue it needs is occupied. The memory controller, the invalidate path and the outgoing response network are all plain valid/ready ports.

Top module: `dma_dir_handler`

## Requirements
- R1: After reset, rsp_valid, mem_req_valid, inv_valid and wake_valid are low, and req_ready and own_ready are high.
- R2: An accepted read (req_write=0) of a line with req_line_modified=0 presents, in the cycle after acceptance, a memory request with mem_req_write=0 and the request's address, and no invalidate.
- R3: Memory data (mem_rsp_is_ack=0) for a pending read produces, in the cycle after it is taken, a response with rsp_is_ack=0, the full data block, the line address and the saved engine ID. In that same cycle wake_valid pulses with the line address.
- R4: An accepted write (req_write=1) of a line with req_line_modified=0 presents, in the cycle after acceptance, a memory request with mem_req_write=1, the request's address, data and byte length.
- R5: A memory acknowledgement (mem_rsp_is_ack=1) for a pending write produces, in the cycle after it is taken, a response with rsp_is_ack=1 and the saved engine ID, together with a wake pulse for the line.
- R6: An accepted read of a line with req_line_modified=1 presents an invalidate for that address in the cycle after acceptance, and no memory request.
- R7: Data returned by the owning cache produces, in the cycle after it is taken, a data response (rsp_is_ack=0) to the saved engine. In the same cycle it presents a memory write-back with mem_req_write=1, the same data and a length of BLOCK_BYTES.
- R8: After a recall, the line stays busy until memory acknowledges the write-back. That acknowledgement produces no response and one wake pulse for the line. No response is ever formed from a slot that no longer holds a requesting engine.
- R9: A request to a line that has an open slot is stalled (req_ready low) until that slot is released. A write to a line with req_line_modified=1 is never accepted.
- R10: While all NUM_TXN slots are busy, a request to any other line is stalled, and it is accepted once a slot is released.
- R11: A response is held with unchanged fields while rsp_ready is low. While it waits, mem_rsp_ready is low.
- R12: Requests from different engines may be outstanding together. Each response carries its own request's engine ID, whatever the completion order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | DMA request present |
| req_ready | output | 1 | DMA request taken this cycle when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_line_modified | input | 1 | Line is held modified by a cache |
| req_addr | input | ADDR_W | Line address |
| req_engine | input | ID_W | ID of the sending engine |
| req_data | input | BLOCK_BYTES*8 | Write data |
| req_len | input | $clog2(BLOCK_BYTES)+1 | Write length in bytes |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory takes the request |
| mem_req_write | output | 1 | 1 = write, 0 = fetch |
| mem_req_addr | output | ADDR_W | Line address |
| mem_req_data | output | BLOCK_BYTES*8 | Write data |
| mem_req_len | output | $clog2(BLOCK_BYTES)+1 | Byte count |
| mem_rsp_valid | input | 1 | Memory answer present |
| mem_rsp_ready | output | 1 | Memory answer taken |
| mem_rsp_is_ack | input | 1 | 1 = write acknowledge, 0 = data |
| mem_rsp_addr | input | ADDR_W | Line address of the answer |
| mem_rsp_data | input | BLOCK_BYTES*8 | Fetched block |
| inv_valid | output | 1 | Invalidate to the owning cache |
| inv_ready | input | 1 | Invalidate taken |
| inv_addr | output | ADDR_W | Line to recall |
| own_valid | input | 1 | Recalled data from the owner present |
| own_ready | output | 1 | Recalled data taken |
| own_addr | input | ADDR_W | Line of the recalled data |
| own_data | input | BLOCK_BYTES*8 | Recalled block |
| rsp_valid | output | 1 | Response to an engine present |
| rsp_ready | input | 1 | Network takes the response |
| rsp_is_ack | output | 1 | 1 = acknowledge, 0 = data |
| rsp_addr | output | ADDR_W | Line address |
| rsp_engine | output | ID_W | Destination engine |
| rsp_data | output | BLOCK_BYTES*8 | Full block for data responses |
| wake_valid | output | 1 | A line's slot was released |
| wake_addr | output | ADDR_W | Released line |

## Verification
The bench builds the block with NUM_TXN=2, a 4-byte block, 12-bit addresses and 3-bit engine IDs. With only two slots, the full-buffer stall is reached with two requests, and out-of-order completion between two engines falls out of the same setup. The small block width keeps every data value readable in a failure line. The 12-bit address lets the table reach both the all-zero and the all-ones line.

// File: rtl/dma_dir_pkg.sv
package dma_dir_pkg;

  typedef enum logic [2:0] {
    TX_FREE    = 3'd0,
    TX_RD_MEM  = 3'd1,
    TX_WR_MEM  = 3'd2,
    TX_RECALL  = 3'd3,
    TX_WB_WAIT = 3'd4
  } txn_state_e;

  // A slot in one of these states still owes a response to an engine.
  function automatic logic holds_requestor(input txn_state_e s);
    return (s == TX_RD_MEM) || (s == TX_WR_MEM) || (s == TX_RECALL);
  endfunction

  // A slot in one of these states expects the next memory answer.
  function automatic logic awaits_memory(input txn_state_e s);
    return (s == TX_RD_MEM) || (s == TX_WR_MEM) || (s == TX_WB_WAIT);
  endfunction

  function automatic txn_state_e open_state(input logic is_write, input logic line_modified);
    if (is_write) return TX_WR_MEM;
    if (line_modified) return TX_RECALL;
    return TX_RD_MEM;
  endfunction

  // Whether the queue the request needs is free; a write to a modified line is never taken.
  function automatic logic req_admissible(input logic is_write, input logic line_modified,
                                          input logic memq_free, input logic invq_free);
    if (is_write && line_modified) return 1'b0;
    if (line_modified) return invq_free;
    return memq_free;
  endfunction

endpackage

// File: rtl/dma_dir_txn_entry.sv
module dma_dir_txn_entry
  import dma_dir_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned ID_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_i,
  input  logic              alloc_write_i,
  input  logic              alloc_modified_i,
  input  logic [ADDR_W-1:0] alloc_addr_i,
  input  logic [ID_W-1:0]   alloc_engine_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [ADDR_W-1:0] mem_addr_i,
  input  logic [ADDR_W-1:0] own_addr_i,
  input  logic              mem_done_i,
  input  logic              own_done_i,
  output logic              busy_o,
  output logic              req_hit_o,
  output logic              mem_hit_o,
  output logic              own_hit_o,
  output txn_state_e        state_o,
  output logic [ID_W-1:0]   engine_o
);

  txn_state_e        state_q;
  logic [ADDR_W-1:0] addr_q;
  logic [ID_W-1:0]   engine_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= TX_FREE;
      addr_q   <= '0;
      engine_q <= '0;
    end else if (alloc_i) begin
      state_q  <= open_state(alloc_write_i, alloc_modified_i);
      addr_q   <= alloc_addr_i;
      engine_q <= alloc_engine_i;
    end else if (mem_done_i) begin
      state_q <= TX_FREE;
    end else if (own_done_i) begin
      state_q <= TX_WB_WAIT;
    end
  end

  always_comb begin
    busy_o    = (state_q != TX_FREE);
    req_hit_o = busy_o && (addr_q == req_addr_i);
    mem_hit_o = awaits_memory(state_q) && (addr_q == mem_addr_i);
    own_hit_o = (state_q == TX_RECALL) && (addr_q == own_addr_i);
    state_o   = state_q;
    engine_o  = engine_q;
  end

  AST_ALLOC_ONLY_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_i |-> (state_q == TX_FREE)); // R10
  AST_OWN_DONE_IN_RECALL: assert property (@(posedge clk) disable iff (!rst_n)
    own_done_i |=> (state_q == TX_WB_WAIT)); // R7
  AST_WB_ACK_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_done_i && state_q == TX_WB_WAIT) |=> (state_q == TX_FREE)); // R8

endmodule

// File: rtl/dma_dir_slot_pick.sv
module dma_dir_slot_pick #(
  parameter int unsigned SLOTS = 4
) (
  input  logic [SLOTS-1:0] busy_i,
  output logic [SLOTS-1:0] grant_o,
  output logic             any_free_o
);

  always_comb begin
    grant_o    = '0;
    any_free_o = 1'b0;
    for (int i = 0; i < SLOTS; i++) begin
      if (!busy_i[i] && !any_free_o) begin
        grant_o[i] = 1'b1;
        any_free_o = 1'b1;
      end
    end
  end

endmodule

// File: rtl/dma_dir_hold_slot.sv
module dma_dir_hold_slot #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic             ready_i,
  output logic             valid_o,
  output logic [WIDTH-1:0] data_o
);

  logic             valid_q;
  logic [WIDTH-1:0] data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else if (load_i) begin
      valid_q <= 1'b1;
      data_q  <= data_i;
    end else if (ready_i) begin
      valid_q <= 1'b0;
    end
  end

  assign valid_o = valid_q;
  assign data_o  = data_q;

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !ready_i) |=> (valid_q && $stable(data_q))); // R11
  AST_LOAD_ONLY_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |-> !valid_q); // R11

endmodule

// File: rtl/dma_dir_handler.sv
module dma_dir_handler
  import dma_dir_pkg::*;
#(
  parameter int unsigned ADDR_W      = 16,
  parameter int unsigned ID_W        = 3,
  parameter int unsigned BLOCK_BYTES = 8,
  parameter int unsigned NUM_TXN     = 4,
  localparam int unsigned DATA_W     = BLOCK_BYTES * 8,
  localparam int unsigned LEN_W      = $clog2(BLOCK_BYTES) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_line_modified,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [ID_W-1:0]   req_engine,
  input  logic [DATA_W-1:0] req_data,
  input  logic [LEN_W-1:0]  req_len,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [DATA_W-1:0] mem_req_data,
  output logic [LEN_W-1:0]  mem_req_len,
  input  logic              mem_rsp_valid,
  output logic              mem_rsp_ready,
  input  logic              mem_rsp_is_ack,
  input  logic [ADDR_W-1:0] mem_rsp_addr,
  input  logic [DATA_W-1:0] mem_rsp_data,
  output logic              inv_valid,
  input  logic              inv_ready,
  output logic [ADDR_W-1:0] inv_addr,
  input  logic              own_valid,
  output logic              own_ready,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic [DATA_W-1:0] own_data,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_is_ack,
  output logic [ADDR_W-1:0] rsp_addr,
  output logic [ID_W-1:0]   rsp_engine,
  output logic [DATA_W-1:0] rsp_data,
  output logic              wake_valid,
  output logic [ADDR_W-1:0] wake_addr
);

  localparam logic [LEN_W-1:0] FULL_LEN = LEN_W'(BLOCK_BYTES);

  typedef struct packed {
    logic              write;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
    logic [LEN_W-1:0]  len;
  } memq_t;

  typedef struct packed {
    logic              is_ack;
    logic [ADDR_W-1:0] addr;
    logic [ID_W-1:0]   engine;
    logic [DATA_W-1:0] data;
  } rsp_t;

  // ---------------- per-slot wires ----------------
  logic [NUM_TXN-1:0] busy_w, req_hit_w, mem_hit_w, own_hit_w, requestor_w;
  logic [NUM_TXN-1:0] grant_w, alloc_w, mem_done_w, own_done_w;
  txn_state_e         state_w  [NUM_TXN];
  logic [ID_W-1:0]    engine_w [NUM_TXN];
  logic               any_free_w;

  // ---------------- named events ----------------
  logic memq_full_w, invq_full_w, rsp_full_w;
  logic mem_fire, own_fire, req_fire, memq_free_for_req;
  logic rsp_load, memq_load, inv_load;
  txn_state_e mem_sel_state;
  logic [ID_W-1:0] mem_sel_engine, own_sel_engine;
  memq_t memq_d, memq_q;
  rsp_t  rsp_d, rsp_q;
  logic  wake_valid_q;
  logic [ADDR_W-1:0] wake_addr_q;

  // ---------------- handshakes ----------------
  assign mem_rsp_ready     = !rsp_full_w;
  assign mem_fire          = mem_rsp_valid && mem_rsp_ready;
  assign own_ready         = !rsp_full_w && !memq_full_w && !mem_rsp_valid;
  assign own_fire          = own_valid && own_ready;
  assign memq_free_for_req = !memq_full_w && !own_fire;
  assign req_ready         = any_free_w && !(|req_hit_w) &&
                             req_admissible(req_write, req_line_modified,
                                            memq_free_for_req, !invq_full_w);
  assign req_fire          = req_valid && req_ready;

  assign alloc_w    = grant_w & {NUM_TXN{req_fire}};
  assign mem_done_w = mem_hit_w & {NUM_TXN{mem_fire}};
  assign own_done_w = own_hit_w & {NUM_TXN{own_fire}};

  // ---------------- transaction slots ----------------
  dma_dir_slot_pick #(.SLOTS(NUM_TXN)) i_pick (
    .busy_i     (busy_w),
    .grant_o    (grant_w),
    .any_free_o (any_free_w)
  );

  for (genvar g = 0; g < NUM_TXN; g++) begin : g_txn
    dma_dir_txn_entry #(.ADDR_W(ADDR_W), .ID_W(ID_W)) i_entry (
      .clk              (clk),
      .rst_n            (rst_n),
      .alloc_i          (alloc_w[g]),
      .alloc_write_i    (req_write),
      .alloc_modified_i (req_line_modified),
      .alloc_addr_i     (req_addr),
      .alloc_engine_i   (req_engine),
      .req_addr_i       (req_addr),
      .mem_addr_i       (mem_rsp_addr),
      .own_addr_i       (own_addr),
      .mem_done_i       (mem_done_w[g]),
      .own_done_i       (own_done_w[g]),
      .busy_o           (busy_w[g]),
      .req_hit_o        (req_hit_w[g]),
      .mem_hit_o        (mem_hit_w[g]),
      .own_hit_o        (own_hit_w[g]),
      .state_o          (state_w[g]),
      .engine_o         (engine_w[g])
    );
    assign requestor_w[g] = holds_requestor(state_w[g]);
  end

  // ---------------- selection of the answering slot ----------------
  always_comb begin
    mem_sel_state  = TX_FREE;
    mem_sel_engine = '0;
    own_sel_engine = '0;
    for (int i = 0; i < NUM_TXN; i++) begin
      if (mem_hit_w[i]) begin
        mem_sel_state  = state_w[i];
        mem_sel_engine = engine_w[i];
      end
      if (own_hit_w[i]) own_sel_engine = engine_w[i];
    end
  end

  // ---------------- response formation ----------------
  always_comb begin
    rsp_load = (mem_fire && holds_requestor(mem_sel_state)) || own_fire;
    if (mem_fire) begin
      rsp_d.is_ack = (mem_sel_state == TX_WR_MEM);
      rsp_d.addr   = mem_rsp_addr;
      rsp_d.engine = mem_sel_engine;
      rsp_d.data   = (mem_sel_state == TX_WR_MEM) ? '0 : mem_rsp_data;
    end else begin
      rsp_d.is_ack = 1'b0;
      rsp_d.addr   = own_addr;
      rsp_d.engine = own_sel_engine;
      rsp_d.data   = own_data;
    end
  end

  // ---------------- memory request formation ----------------
  always_comb begin
    memq_load = own_fire || (req_fire && !req_line_modified);
    inv_load  = req_fire && req_line_modified;
    if (own_fire) begin
      memq_d.write = 1'b1;
      memq_d.addr  = own_addr;
      memq_d.data  = own_data;
      memq_d.len   = FULL_LEN;
    end else begin
      memq_d.write = req_write;
      memq_d.addr  = req_addr;
      memq_d.data  = req_write ? req_data : '0;
      memq_d.len   = req_write ? req_len : FULL_LEN;
    end
  end

  dma_dir_hold_slot #(.WIDTH($bits(memq_t))) i_memq (
    .clk (clk), .rst_n (rst_n), .load_i (memq_load), .data_i (memq_d),
    .ready_i (mem_req_ready), .valid_o (memq_full_w), .data_o (memq_q)
  );

  logic [ADDR_W-1:0] inv_q;
  dma_dir_hold_slot #(.WIDTH(ADDR_W)) i_invq (
    .clk (clk), .rst_n (rst_n), .load_i (inv_load), .data_i (req_addr),
    .ready_i (inv_ready), .valid_o (invq_full_w), .data_o (inv_q)
  );

  dma_dir_hold_slot #(.WIDTH($bits(rsp_t))) i_rspq (
    .clk (clk), .rst_n (rst_n), .load_i (rsp_load), .data_i (rsp_d),
    .ready_i (rsp_ready), .valid_o (rsp_full_w), .data_o (rsp_q)
  );

  // ---------------- wake announcement ----------------
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wake_valid_q <= 1'b0;
      wake_addr_q  <= '0;
    end else begin
      wake_valid_q <= |mem_done_w;
      wake_addr_q  <= mem_rsp_addr;
    end
  end

  assign mem_req_valid = memq_full_w;
  assign mem_req_write = memq_q.write;
  assign mem_req_addr  = memq_q.addr;
  assign mem_req_data  = memq_q.data;
  assign mem_req_len   = memq_q.len;
  assign inv_valid     = invq_full_w;
  assign inv_addr      = inv_q;
  assign rsp_valid     = rsp_full_w;
  assign rsp_is_ack    = rsp_q.is_ack;
  assign rsp_addr      = rsp_q.addr;
  assign rsp_engine    = rsp_q.engine;
  assign rsp_data      = rsp_q.data;
  assign wake_valid    = wake_valid_q;
  assign wake_addr     = wake_addr_q;

  // ---------------- assertions ----------------
  AST_ONE_SLOT_PER_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req_hit_w) && $onehot0(mem_hit_w)); // R9
  AST_NO_MODIFIED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire |-> !(req_write && req_line_modified)); // R9
  AST_MEM_RSP_HAS_TXN: assert property (@(posedge clk) disable iff (!rst_n)
    mem_fire |-> (|mem_hit_w)); // R8
  AST_OWN_DATA_HAS_TXN: assert property (@(posedge clk) disable iff (!rst_n)
    own_fire |-> (|own_hit_w)); // R7
  AST_RSP_NEEDS_TXN: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_load |-> (|((mem_hit_w | own_hit_w) & requestor_w))); // R12
  AST_READ_GETS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_fire && mem_sel_state == TX_RD_MEM) |-> !mem_rsp_is_ack); // R3
  AST_WRITE_GETS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_fire && mem_sel_state == TX_WR_MEM) |-> mem_rsp_is_ack); // R5
  AST_WAKE_AFTER_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    wake_valid_q |-> $past(mem_fire)); // R3

endmodule

// File: tb/test_dma_dir_handler.sv
module test_dma_dir_handler;

  localparam int unsigned AW = 12;
  localparam int unsigned IW = 3;
  localparam int unsigned BB = 4;
  localparam int unsigned DW = BB * 8;
  localparam int unsigned LW = $clog2(BB) + 1;
  localparam int unsigned NT = 2;

  typedef struct packed {
    logic          wr;
    logic          modi;
    logic [AW-1:0] addr;
    logic [IW-1:0] eng;
    logic [DW-1:0] data;
    logic [LW-1:0] len;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{wr:1'b0, modi:1'b0, addr:12'h010, eng:3'd1, data:32'hA5A50001, len:3'd4},
    '{wr:1'b1, modi:1'b0, addr:12'h020, eng:3'd6, data:32'h12345678, len:3'd2},
    '{wr:1'b0, modi:1'b1, addr:12'h030, eng:3'd3, data:32'hDEADBEEF, len:3'd4},
    '{wr:1'b1, modi:1'b0, addr:12'hFFF, eng:3'd7, data:32'hFFFF0000, len:3'd1},
    '{wr:1'b0, modi:1'b0, addr:12'h000, eng:3'd0, data:32'h80000001, len:3'd4},
    '{wr:1'b0, modi:1'b1, addr:12'h7A5, eng:3'd5, data:32'h0BADF00D, len:3'd4}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, req_ready, req_write, req_line_modified;
  logic [AW-1:0] req_addr;
  logic [IW-1:0] req_engine;
  logic [DW-1:0] req_data;
  logic [LW-1:0] req_len;
  logic mem_req_valid, mem_req_ready, mem_req_write;
  logic [AW-1:0] mem_req_addr;
  logic [DW-1:0] mem_req_data;
  logic [LW-1:0] mem_req_len;
  logic mem_rsp_valid, mem_rsp_ready, mem_rsp_is_ack;
  logic [AW-1:0] mem_rsp_addr;
  logic [DW-1:0] mem_rsp_data;
  logic inv_valid, inv_ready;
  logic [AW-1:0] inv_addr;
  logic own_valid, own_ready;
  logic [AW-1:0] own_addr;
  logic [DW-1:0] own_data;
  logic rsp_valid, rsp_ready, rsp_is_ack;
  logic [AW-1:0] rsp_addr;
  logic [IW-1:0] rsp_engine;
  logic [DW-1:0] rsp_data;
  logic wake_valid;
  logic [AW-1:0] wake_addr;

  int n_checks = 0;
  int n_err = 0;

  always #2 clk = ~clk;

  dma_dir_handler #(.ADDR_W(AW), .ID_W(IW), .BLOCK_BYTES(BB), .NUM_TXN(NT)) i_dma_dir_handler (
    .clk (clk), .rst_n (rst_n),
    .req_valid (req_valid), .req_ready (req_ready), .req_write (req_write),
    .req_line_modified (req_line_modified), .req_addr (req_addr), .req_engine (req_engine),
    .req_data (req_data), .req_len (req_len),
    .mem_req_valid (mem_req_valid), .mem_req_ready (mem_req_ready), .mem_req_write (mem_req_write),
    .mem_req_addr (mem_req_addr), .mem_req_data (mem_req_data), .mem_req_len (mem_req_len),
    .mem_rsp_valid (mem_rsp_valid), .mem_rsp_ready (mem_rsp_ready), .mem_rsp_is_ack (mem_rsp_is_ack),
    .mem_rsp_addr (mem_rsp_addr), .mem_rsp_data (mem_rsp_data),
    .inv_valid (inv_valid), .inv_ready (inv_ready), .inv_addr (inv_addr),
    .own_valid (own_valid), .own_ready (own_ready), .own_addr (own_addr), .own_data (own_data),
    .rsp_valid (rsp_valid), .rsp_ready (rsp_ready), .rsp_is_ack (rsp_is_ack), .rsp_addr (rsp_addr),
    .rsp_engine (rsp_engine), .rsp_data (rsp_data),
    .wake_valid (wake_valid), .wake_addr (wake_addr)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_req(input logic wr, input logic modi, input logic [AW-1:0] a,
                        input logic [IW-1:0] e, input logic [DW-1:0] d, input logic [LW-1:0] l);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_line_modified = modi;
    req_addr = a; req_engine = e; req_data = d; req_len = l;
    #1;
    for (int w = 0; w < 50 && !req_ready; w++) begin
      @(negedge clk); #1;
    end
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic do_mem(input logic ack, input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    mem_rsp_valid = 1'b1; mem_rsp_is_ack = ack; mem_rsp_addr = a; mem_rsp_data = d;
    #1;
    for (int w = 0; w < 50 && !mem_rsp_ready; w++) begin
      @(negedge clk); #1;
    end
    @(posedge clk); #1;
    mem_rsp_valid = 1'b0;
  endtask

  task automatic do_own(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    own_valid = 1'b1; own_addr = a; own_data = d;
    #1;
    for (int w = 0; w < 50 && !own_ready; w++) begin
      @(negedge clk); #1;
    end
    @(posedge clk); #1;
    own_valid = 1'b0;
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    n_checks++;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    req_valid = 0; req_write = 0; req_line_modified = 0; req_addr = '0; req_engine = '0;
    req_data = '0; req_len = '0;
    mem_req_ready = 1'b1; inv_ready = 1'b1; rsp_ready = 1'b1;
    mem_rsp_valid = 0; mem_rsp_is_ack = 0; mem_rsp_addr = '0; mem_rsp_data = '0;
    own_valid = 0; own_addr = '0; own_data = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk("R1 rsp_valid", rsp_valid, 0);
    chk("R1 mem_req_valid", mem_req_valid, 0);
    chk("R1 inv_valid", inv_valid, 0);
    chk("R1 wake_valid", wake_valid, 0);
    chk("R1 req_ready", req_ready, 1);
    chk("R1 own_ready", own_ready, 1);

    // Table walk: one complete flow per vector
    foreach (VEC[i]) begin
      vec_t v = VEC[i];
      do_req(v.wr, v.modi, v.addr, v.eng, v.data, v.len);
      if (v.modi) begin
        chk("R6 inv_valid", inv_valid, 1);
        chk("R6 inv_addr", inv_addr, v.addr);
        chk("R6 no mem_req", mem_req_valid, 0);
        do_own(v.addr, v.data);
        chk("R7 rsp_valid", rsp_valid, 1);
        chk("R7 rsp_is_ack", rsp_is_ack, 0);
        chk("R7 rsp_engine", rsp_engine, v.eng);
        chk("R7 rsp_data", rsp_data, v.data);
        chk("R7 wb valid", mem_req_valid, 1);
        chk("R7 wb write", mem_req_write, 1);
        chk("R7 wb addr", mem_req_addr, v.addr);
        chk("R7 wb data", mem_req_data, v.data);
        chk("R7 wb len", mem_req_len, BB);
        chk("R8 no wake yet", wake_valid, 0);
        do_mem(1'b1, v.addr, '0);
        chk("R8 no response", rsp_valid, 0);
        chk("R8 wake_valid", wake_valid, 1);
        chk("R8 wake_addr", wake_addr, v.addr);
      end else if (v.wr) begin
        chk("R4 mem_req_valid", mem_req_valid, 1);
        chk("R4 mem_req_write", mem_req_write, 1);
        chk("R4 mem_req_addr", mem_req_addr, v.addr);
        chk("R4 mem_req_data", mem_req_data, v.data);
        chk("R4 mem_req_len", mem_req_len, v.len);
        do_mem(1'b1, v.addr, '0);
        chk("R5 rsp_valid", rsp_valid, 1);
        chk("R5 rsp_is_ack", rsp_is_ack, 1);
        chk("R5 rsp_engine", rsp_engine, v.eng);
        chk("R5 rsp_addr", rsp_addr, v.addr);
        chk("R5 wake_addr", {wake_valid, wake_addr}, {1'b1, v.addr});
      end else begin
        chk("R2 mem_req_valid", mem_req_valid, 1);
        chk("R2 mem_req_write", mem_req_write, 0);
        chk("R2 mem_req_addr", mem_req_addr, v.addr);
        chk("R2 no inv", inv_valid, 0);
        do_mem(1'b0, v.addr, v.data ^ 32'h5A5A5A5A);
        chk("R3 rsp_valid", rsp_valid, 1);
        chk("R3 rsp_is_ack", rsp_is_ack, 0);
        chk("R3 rsp_engine", rsp_engine, v.eng);
        chk("R3 rsp_data", rsp_data, v.data ^ 32'h5A5A5A5A);
        chk("R3 rsp_addr", rsp_addr, v.addr);
        chk("R3 wake", {wake_valid, wake_addr}, {1'b1, v.addr});
      end
    end

    // R9: same-line request stalls until release; write to modified line never taken
    do_req(1'b0, 1'b0, 12'h100, 3'd2, '0, 3'd4);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_line_modified = 1'b0; req_addr = 12'h100;
    repeat (2) @(negedge clk);
    #1;
    chk("R9 same line stalled", req_ready, 0);
    req_addr = 12'h200; req_line_modified = 1'b1;
    #1;
    chk("R9 write to modified stalled", req_ready, 0);
    req_valid = 1'b0; req_line_modified = 1'b0;
    do_mem(1'b0, 12'h100, 32'h00000100);
    @(negedge clk);
    req_addr = 12'h100; req_write = 1'b1;
    #1;
    chk("R9 ready after wake", req_ready, 1);

    // R10 / R12: fill both slots, then complete in reverse order
    do_req(1'b0, 1'b0, 12'h300, 3'd4, '0, 3'd4);
    do_req(1'b1, 1'b0, 12'h301, 3'd5, 32'hCAFE0301, 3'd3);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 12'h302;
    repeat (2) @(negedge clk);
    #1;
    chk("R10 full stalled", req_ready, 0);
    req_valid = 1'b0;
    do_mem(1'b1, 12'h301, '0);
    chk("R12 second engine first", rsp_engine, 3'd5);
    chk("R12 ack type", rsp_is_ack, 1);
    @(negedge clk);
    req_addr = 12'h302;
    #1;
    chk("R10 ready after release", req_ready, 1);
    do_mem(1'b0, 12'h300, 32'h00000300);
    chk("R12 first engine later", rsp_engine, 3'd4);
    chk("R12 data", rsp_data, 32'h00000300);

    // R11: response held under back-pressure
    do_req(1'b0, 1'b0, 12'h400, 3'd6, '0, 3'd4);
    rsp_ready = 1'b0;
    do_mem(1'b0, 12'h400, 32'h44440400);
    repeat (3) @(posedge clk);
    #1;
    chk("R11 held valid", rsp_valid, 1);
    chk("R11 held data", rsp_data, 32'h44440400);
    chk("R11 held engine", rsp_engine, 3'd6);
    chk("R11 memory blocked", mem_rsp_ready, 0);
    @(negedge clk);
    rsp_ready = 1'b1;
    @(posedge clk); #1;
    chk("R11 released", rsp_valid, 0);

    finish_run();
  end

endmodule